// File: doc/BRIEF.md
# Dual-Slope Current Converter Sweep Sequencer

This block is the digital side of a dual-slope converter that digitises small on-chip reference currents. For each measurement it first lets the unknown current charge an integration capacitor. It then holds a correlated-double-sampling interval. Finally it switches a known reference current in to discharge the capacitor. While the capacitor discharges, the block counts clock cycles. It freezes the count when the analog comparator reports that the capacitor voltage has crossed zero. The frozen count is proportional to the measured current.

One start pulse launches a sweep over a whole bank of calibration sources. The sources are measured one after the other in ascending index order. Each one produces a code with a valid strobe. The sweep ends with a done pulse, after which the block waits for the next start. The comparator is asynchronous to the clock, so it is resynchronised inside the block. A measurement that never sees a crossing saturates and is flagged.

Top module: `dsadc_sweep`

## Requirements
- R1: While reset is held and after its release, all phase outputs, `code_vld_o`, `done_o`, `ovr_o` and `code_o` are 0, and `src_sel_o` is 0.
- R2: A start in idle enters the charge phase for source 0. `chg_en_o` is high for exactly PRE_CYC cycles, and the other phase outputs are low during that time.
- R3: The charge phase is followed by the sampling phase, in which `cds_en_o` is high for exactly CDS_CYC cycles. The discharge phase (`dis_en_o`) follows it. At most one phase output is high in any cycle.
- R4: During discharge the count starts at 0 on the entering edge and rises by one per cycle. `cmp_i` passes through two flops. If `cmp_i` is first sampled high at the (K+1)-th rising edge after the entering edge, the latched code is K+2.
- R5: `code_vld_o` is a single-cycle pulse in the cycle after the latch. In that cycle `dis_en_o` is already low and `src_sel_o` still shows the measured source.
- R6: If the count reaches all ones (2^CODE_W-1) before a synchronised high sample is seen, the code is all ones and `ovr_o` is 1. A synchronised high sample on that same edge gives all ones with `ovr_o` at 0. `ovr_o` is meaningful together with each code and is 0 otherwise.
- R7: A sweep measures sources 0 to NUM_SRC-1 once each, in ascending order, with one code per source.
- R8: `done_o` pulses for one cycle, exactly in the cycle after the last source's valid. The block then idles with all phases low and `src_sel_o` at 0.
- R9: A start pulse during a sweep is ignored. The sweep still yields exactly NUM_SRC codes and one done pulse, and no further measurement starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a sweep (honoured only in idle) |
| cmp_i | input | 1 | Asynchronous comparator output, high at zero crossing |
| chg_en_o | output | 1 | Charge phase: unknown current onto capacitor |
| cds_en_o | output | 1 | Correlated double sampling phase |
| dis_en_o | output | 1 | Discharge phase: reference current active, counting |
| src_sel_o | output | $clog2(NUM_SRC) | Index of calibration source being measured |
| code_o | output | CODE_W | Latched conversion code |
| code_vld_o | output | 1 | One-cycle strobe for a new code |
| ovr_o | output | 1 | Code saturated without a crossing |
| done_o | output | 1 | One-cycle pulse at the end of the sweep |

## Verification
The hardest situation to reach is the saturation boundary. In that case the synchronised comparator sample and the all-ones count meet on the same clock edge, or miss each other by exactly one edge. A responder process in the bench watches for the start of discharge. It raises the comparator after a programmed number of cycles, so the delays of 253 and 254 cycles on an 8-bit bench instance land on either side of that edge. A delay longer than full scale drives the no-crossing case. A second start pulse issued during discharge probes the busy state.

// File: rtl/dsq_pkg.sv
// Package: shared state encoding for the dual-slope sweep sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CHG  = 3'd1,
        ST_CDS  = 3'd2,
        ST_DIS  = 3'd3,
        ST_NEXT = 3'd4
    } dsq_state_e;
endpackage

// File: rtl/dsq_sync2.sv
// Module: two-flop synchroniser for the asynchronous comparator input.
// Assumes: the input is level-like and stays high for several clocks.
module dsq_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;

    // Two sequential stages; the second one feeds the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/dsq_ctrl.sv
// Module: phase sequencer and shared cycle counter.
// The counter times the charge and sampling phases, and it is the conversion count
// during discharge. The module walks the source index across the bank.
// Assumes: PRE_CYC and CDS_CYC are >= 1 and fit in CODE_W bits; NUM_SRC >= 2.
module dsq_ctrl
    import dsq_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int NUM_SRC = 12,
    parameter int PRE_CYC = 16,
    parameter int CDS_CYC = 8,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_s_i,
    output logic              chg_en_o,
    output logic              cds_en_o,
    output logic              dis_en_o,
    output logic [SEL_W-1:0]  src_o,
    output logic [CODE_W-1:0] cnt_o,
    output logic              latch_o,
    output logic              sat_o,
    output logic              done_o
);
    localparam logic [CODE_W-1:0] FULL     = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] PRE_LAST = CODE_W'(PRE_CYC - 1);
    localparam logic [CODE_W-1:0] CDS_LAST = CODE_W'(CDS_CYC - 1);
    localparam logic [SEL_W-1:0]  SRC_LAST = SEL_W'(NUM_SRC - 1);

    dsq_state_e state_q;
    logic       at_full;

    // Decode of the phase outputs and of the latch/saturate strobes.
    always_comb begin
        at_full  = (cnt_o == FULL);
        chg_en_o = (state_q == ST_CHG);
        cds_en_o = (state_q == ST_CDS);
        dis_en_o = (state_q == ST_DIS);
        latch_o  = (state_q == ST_DIS) && (cmp_s_i || at_full);
        sat_o    = (state_q == ST_DIS) && !cmp_s_i && at_full;
    end

    // State, counter, source index and done pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_o   <= '0;
            src_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_CHG;
                        cnt_o   <= '0;
                        src_o   <= '0;
                    end
                end
                ST_CHG: begin
                    if (cnt_o == PRE_LAST) begin
                        state_q <= ST_CDS;
                        cnt_o   <= '0;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end
                ST_CDS: begin
                    if (cnt_o == CDS_LAST) begin
                        state_q <= ST_DIS;
                        cnt_o   <= '0;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end
                ST_DIS: begin
                    if (cmp_s_i || at_full) begin
                        state_q <= ST_NEXT;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end
                ST_NEXT: begin
                    cnt_o <= '0;
                    if (src_o == SRC_LAST) begin
                        state_q <= ST_IDLE;
                        src_o   <= '0;
                        done_o  <= 1'b1;
                    end else begin
                        state_q <= ST_CHG;
                        src_o   <= src_o + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsq_result.sv
// Module: result register. It captures the count and the saturation flag on a
// latch strobe and issues a one-cycle valid.
// Assumes: the latch strobe is a single-cycle pulse from the controller.
module dsq_result #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              sat_i,
    input  logic [CODE_W-1:0] cnt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ovr_o,
    output logic              vld_o
);
    // Hold code and flag; the valid follows the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            ovr_o  <= 1'b0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= latch_i;
            if (latch_i) begin
                code_o <= cnt_i;
                ovr_o  <= sat_i;
            end
        end
    end
endmodule

// File: rtl/dsadc_sweep.sv
// Module: top of the dual-slope current converter sweep sequencer.
// Assumes: cmp_i is asynchronous and rises only during discharge. The analog
// integrator, comparator and current sources are outside this block.
module dsadc_sweep #(
    parameter int CODE_W  = 16,
    parameter int NUM_SRC = 12,
    parameter int PRE_CYC = 16,
    parameter int CDS_CYC = 8,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic              chg_en_o,
    output logic              cds_en_o,
    output logic              dis_en_o,
    output logic [SEL_W-1:0]  src_sel_o,
    output logic [CODE_W-1:0] code_o,
    output logic              code_vld_o,
    output logic              ovr_o,
    output logic              done_o
);
    logic              cmp_s;
    logic [CODE_W-1:0] cnt;
    logic              latch;
    logic              sat;

    dsq_sync2 i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_i),
        .sync_o  (cmp_s)
    );

    dsq_ctrl #(
        .CODE_W  (CODE_W),
        .NUM_SRC (NUM_SRC),
        .PRE_CYC (PRE_CYC),
        .CDS_CYC (CDS_CYC)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cmp_s_i  (cmp_s),
        .chg_en_o (chg_en_o),
        .cds_en_o (cds_en_o),
        .dis_en_o (dis_en_o),
        .src_o    (src_sel_o),
        .cnt_o    (cnt),
        .latch_o  (latch),
        .sat_o    (sat),
        .done_o   (done_o)
    );

    dsq_result #(
        .CODE_W (CODE_W)
    ) i_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_i (latch),
        .sat_i   (sat),
        .cnt_i   (cnt),
        .code_o  (code_o),
        .ovr_o   (ovr_o),
        .vld_o   (code_vld_o)
    );
endmodule

// File: rtl/dsadc_sweep_chk.sv
// Module: property checker attached to the sequencer top through bind.
// Assumes: synchronous active-low reset on rst_n.
module dsadc_sweep_chk #(
    parameter int CODE_W  = 16,
    parameter int NUM_SRC = 12,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cmp_i,
    input logic              chg_en_o,
    input logic              cds_en_o,
    input logic              dis_en_o,
    input logic [SEL_W-1:0]  src_sel_o,
    input logic [CODE_W-1:0] code_o,
    input logic              code_vld_o,
    input logic              ovr_o,
    input logic              done_o
);
    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chg_en_o, cds_en_o, dis_en_o})); // R3
    AST_CDS_AFTER_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cds_en_o) |-> $past(chg_en_o)); // R3
    AST_DIS_AFTER_CDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_en_o) |-> $past(cds_en_o)); // R3
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |=> !code_vld_o); // R5
    AST_VLD_OUT_OF_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |-> !dis_en_o && $past(dis_en_o)); // R5
    AST_OVR_FULL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (code_o == {CODE_W{1'b1}})); // R6
    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_o <= SEL_W'(NUM_SRC - 1)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !chg_en_o && !cds_en_o && !dis_en_o && (src_sel_o == '0)); // R8
    AST_DONE_AFTER_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(code_vld_o)); // R8
endmodule

bind dsadc_sweep dsadc_sweep_chk #(
    .CODE_W  (CODE_W),
    .NUM_SRC (NUM_SRC)
) i_chk (.*);

// File: tb/test_dsadc_sweep.sv
// Scoreboard bench for the dual-slope sweep sequencer (8-bit, 4-source instance).
module test_dsadc_sweep;
    localparam int CODE_W  = 8;
    localparam int NUM_SRC = 4;
    localparam int PRE_CYC = 4;
    localparam int CDS_CYC = 3;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int MAXV    = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              cmp_i = 1'b0;
    logic              chg_en_o, cds_en_o, dis_en_o;
    logic [SEL_W-1:0]  src_sel_o;
    logic [CODE_W-1:0] code_o;
    logic              code_vld_o, ovr_o, done_o;

    always #2 clk = ~clk;

    dsadc_sweep #(
        .CODE_W (CODE_W), .NUM_SRC (NUM_SRC), .PRE_CYC (PRE_CYC), .CDS_CYC (CDS_CYC)
    ) i_dsadc_sweep (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .cmp_i (cmp_i),
        .chg_en_o (chg_en_o), .cds_en_o (cds_en_o), .dis_en_o (dis_en_o),
        .src_sel_o (src_sel_o), .code_o (code_o), .code_vld_o (code_vld_o),
        .ovr_o (ovr_o), .done_o (done_o)
    );

    typedef struct {
        int src;
        int code;
        bit ovr;
    } exp_t;

    exp_t exp_q[$];
    int   dly_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   done_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // Driver: queue expectations and delays, launch a sweep, optionally poke start while busy.
    task automatic run_sweep(input int ks[NUM_SRC], input bit poke);
        int d0;
        for (int i = 0; i < NUM_SRC; i++) begin
            exp_t e;
            e.src  = i;
            e.code = (ks[i] + 2 > MAXV) ? MAXV : ks[i] + 2;   // R4 / R6
            e.ovr  = (ks[i] + 2 > MAXV);
            exp_q.push_back(e);
            dly_q.push_back(ks[i]);
        end
        d0 = done_cnt;
        pulse_start();
        if (poke) begin
            wait (dis_en_o === 1'b1);
            pulse_start();                                       // R9: ignored while busy
        end
        wait (done_cnt != d0);
        repeat (30) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
        chk({chg_en_o, cds_en_o, dis_en_o} == 3'b000, "R8 idle phases",
            int'({chg_en_o, cds_en_o, dis_en_o}), 0);
        chk(src_sel_o == '0, "R8 idle src", int'(src_sel_o), 0);
        chk(exp_q.size() == 0, "R7 all sources measured", exp_q.size(), 0);
    endtask

    // Responder: models the comparator crossing K cycles into discharge.
    initial begin
        forever begin
            int k;
            wait (dis_en_o === 1'b1);
            @(negedge clk);
            k = (dly_q.size() > 0) ? dly_q.pop_front() : 0;
            for (int i = 0; i < k; i++) begin
                if (!dis_en_o) break;
                @(negedge clk);
            end
            if (dis_en_o) cmp_i = 1'b1;
            wait (dis_en_o === 1'b0);
            @(negedge clk) cmp_i = 1'b0;
        end
    end

    // Monitor: phase lengths, scoreboard pops on valid, done placement.
    int chg_run = 0, cds_run = 0;
    bit prev_chg = 0, prev_cds = 0, prev_vld = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (chg_en_o) chg_run++;
            if (prev_chg && !chg_en_o) begin
                chk(chg_run == PRE_CYC, "R2 charge length", chg_run, PRE_CYC);
                chg_run = 0;
            end
            if (cds_en_o) cds_run++;
            if (prev_cds && !cds_en_o) begin
                chk(cds_run == CDS_CYC, "R3 sample length", cds_run, CDS_CYC);
                chk(dis_en_o, "R3 discharge follows", int'(dis_en_o), 1);
                cds_run = 0;
            end
            if (code_vld_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected code", int'(code_o), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(src_sel_o) == e.src, "R7 source order", int'(src_sel_o), e.src);
                    chk(int'(code_o) == e.code, "R4 code value", int'(code_o), e.code);
                    chk(ovr_o == e.ovr, "R6 overrange flag", int'(ovr_o), int'(e.ovr));
                end
            end
            if (done_o) begin
                done_cnt++;
                chk(prev_vld, "R8 done after last valid", int'(prev_vld), 1);
            end
            prev_chg = chg_en_o;
            prev_cds = cds_en_o;
            prev_vld = code_vld_o;
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk({chg_en_o, cds_en_o, dis_en_o, code_vld_o, done_o, ovr_o} == 6'b0,
                    "R1 flags in reset", int'({chg_en_o, cds_en_o, dis_en_o, code_vld_o, done_o, ovr_o}), 0);
                @(negedge clk) rst_n = 1'b1;
                repeat (2) @(negedge clk);
                chk(code_o == '0, "R1 code after reset", int'(code_o), 0);
                chk(src_sel_o == '0, "R1 src after reset", int'(src_sel_o), 0);
                chk(!chg_en_o && !done_o, "R1 idle after reset", int'(chg_en_o), 0);
                run_sweep('{0, 5, 40, 100}, 1'b0);
                run_sweep('{253, 254, 300, 7}, 1'b1);   // R6 boundary pair and no-crossing case
            end
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule